// File: doc/BRIEF.md
# Offset Calibration Coefficient Bank

This block keeps one offset calibration coefficient per converter channel and serves them on a simple register bus. On reset every coefficient takes a power-on value presented on an input vector, so the surrounding chip can feed in factory-trimmed numbers. Afterwards a coefficient changes in only two ways: a calibration engine finishing an offset calibration on that channel presents a result strobe with a value, or software writes it over the bus.

Software writes are guarded. A channel accepts a write only while it is enabled, in idle mode, and has stayed both for at least `IDLE_CYCLES` consecutive clock edges. Each channel has a saturating idle timer that restarts whenever the channel is disabled or leaves idle. A refused write leaves the coefficient untouched and raises a sticky per-channel error bit in a status word that clears when read. Reads of coefficients are always allowed.

Top module: `cal_coef_bank`

## Requirements
- R1: A read with `bus_addr_i` equal to channel index c (0 to NUM_CH-1) returns that channel's current coefficient on `bus_rdata_o` in the same cycle, whatever the channel's enable and idle inputs are.
- R2: While `rst_ni` is low, coefficient c takes the value `reset_coef_i[c*COEF_W +: COEF_W]`, and all status error bits are 0.
- R3: When `cal_done_i[c]` is high at a clock edge, coefficient c holds `cal_value_i[c*COEF_W +: COEF_W]` after that edge, whether or not the channel is enabled or idle.
- R4: A bus write to address c is applied at the next edge only if, at that edge, `ch_enable_i[c]` and `ch_idle_i[c]` are high and were high at each of the preceding `IDLE_CYCLES` edges.
- R5: A single edge at which the channel is disabled or not idle restarts the idle count from zero, so a write needs a fresh run of `IDLE_CYCLES` edges.
- R6: A write to address c that is not applied leaves coefficient c unchanged and sets bit c of the status word at address NUM_CH; the bit stays set until cleared.
- R7: A read at the status address (`bus_rd_i` high, `bus_addr_i` equal to NUM_CH) returns the error bits in bits NUM_CH-1:0, zero above, and clears them at that edge.
- R8: When a calibration strobe and a bus write hit the same channel at the same edge, the calibration value is stored and the write counts as refused (its error bit is set).
- R9: A bus write to the status address changes no coefficient and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, loads the power-on coefficients |
| reset_coef_i | input | NUM_CH*COEF_W | Power-on coefficient per channel |
| ch_enable_i | input | NUM_CH | Channel enabled |
| ch_idle_i | input | NUM_CH | Channel in idle mode |
| cal_done_i | input | NUM_CH | Calibration result strobe per channel |
| cal_value_i | input | NUM_CH*COEF_W | Calibration result per channel |
| bus_wr_i | input | 1 | Bus write request |
| bus_rd_i | input | 1 | Bus read request (used for read-to-clear) |
| bus_addr_i | input | ADDR_W | Word address: channels, then status |
| bus_wdata_i | input | COEF_W | Write data |
| bus_rdata_o | output | COEF_W | Read data, combinational from address |

## Verification
The two update sources that can meet on one channel at one edge are the calibration strobe and a permitted software write. The bench brings a channel to exactly the permitted state, then raises the strobe with a different value in the same cycle as the write, and judges the outcome by reading the coefficient (it must be the calibration value) and the status word (the channel's error bit must be set). The same idle-window sweep run without the strobe shows the write alone would have been accepted, so the result is due to priority and not to gating.

// File: rtl/cal_coef_pkg.sv
package cal_coef_pkg;

    // Kind of target selected by a bus address.
    typedef enum logic [1:0] {
        SEL_COEF = 2'd0,
        SEL_STAT = 2'd1,
        SEL_NONE = 2'd2
    } sel_kind_e;

    // Decode an address into a target kind; index is the address itself.
    function automatic sel_kind_e decode_sel(input int unsigned addr,
                                             input int unsigned num_ch);
        if (addr < num_ch)       return SEL_COEF;
        else if (addr == num_ch) return SEL_STAT;
        else                     return SEL_NONE;
    endfunction

endpackage

// File: rtl/cal_idle_timer.sv
module cal_idle_timer #(
    parameter int IDLE_CYCLES = 1150
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic idle_i,
    output logic permit_o
);
    localparam int CNT_W = (IDLE_CYCLES < 1) ? 1 : $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic quiet;

    always_comb begin
        quiet = enable_i && idle_i;
        st_d  = st_q;
        if (!quiet) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        permit_o = quiet && (st_q.cnt == CNT_MAX);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/cal_coef_slot.sv
module cal_coef_slot #(
    parameter int COEF_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [COEF_W-1:0] default_i,
    input  logic              cal_strobe_i,
    input  logic [COEF_W-1:0] cal_value_i,
    input  logic              wr_hit_i,
    input  logic              permit_i,
    input  logic [COEF_W-1:0] wdata_i,
    output logic [COEF_W-1:0] coef_o,
    output logic              reject_o
);
    typedef struct packed {
        logic [COEF_W-1:0] coef;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        reject_o = 1'b0;
        if (cal_strobe_i) begin
            st_d.coef = cal_value_i;
            reject_o  = wr_hit_i;
        end else if (wr_hit_i) begin
            if (permit_i) st_d.coef = wdata_i;
            else          reject_o  = 1'b1;
        end
        coef_o = st_q.coef;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q.coef <= default_i;
        else         st_q      <= st_d;
    end
endmodule

// File: rtl/cal_err_status.sv
module cal_err_status #(
    parameter int NUM_CH = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] reject_i,
    input  logic              clear_i,
    output logic [NUM_CH-1:0] err_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] err;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d.err = (clear_i ? '0 : st_q.err) | reject_i;
        err_o    = st_q.err;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/cal_coef_bank.sv
module cal_coef_bank #(
    parameter int NUM_CH      = 3,
    parameter int COEF_W      = 16,
    parameter int IDLE_CYCLES = 1150,
    parameter int ADDR_W      = $clog2(NUM_CH + 1)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_CH*COEF_W-1:0] reset_coef_i,
    input  logic [NUM_CH-1:0]        ch_enable_i,
    input  logic [NUM_CH-1:0]        ch_idle_i,
    input  logic [NUM_CH-1:0]        cal_done_i,
    input  logic [NUM_CH*COEF_W-1:0] cal_value_i,
    input  logic                     bus_wr_i,
    input  logic                     bus_rd_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic [COEF_W-1:0]        bus_wdata_i,
    output logic [COEF_W-1:0]        bus_rdata_o
);
    import cal_coef_pkg::*;

    localparam int PAD_W = COEF_W - NUM_CH;

    sel_kind_e              sel;
    logic [NUM_CH-1:0]      wr_hit;
    logic [NUM_CH-1:0]      permit;
    logic [NUM_CH-1:0]      reject;
    logic [NUM_CH*COEF_W-1:0] coef_flat;
    logic [NUM_CH-1:0]      err;
    logic                   stat_clear;

    always_comb begin
        sel        = decode_sel(int'(bus_addr_i), NUM_CH);
        stat_clear = bus_rd_i && (sel == SEL_STAT);
        for (int c = 0; c < NUM_CH; c++) begin
            wr_hit[c] = bus_wr_i && (sel == SEL_COEF) && (int'(bus_addr_i) == c);
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cal_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .enable_i (ch_enable_i[c]),
            .idle_i   (ch_idle_i[c]),
            .permit_o (permit[c])
        );

        cal_coef_slot #(.COEF_W(COEF_W)) u_slot (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .default_i    (reset_coef_i[c*COEF_W +: COEF_W]),
            .cal_strobe_i (cal_done_i[c]),
            .cal_value_i  (cal_value_i[c*COEF_W +: COEF_W]),
            .wr_hit_i     (wr_hit[c]),
            .permit_i     (permit[c]),
            .wdata_i      (bus_wdata_i),
            .coef_o       (coef_flat[c*COEF_W +: COEF_W]),
            .reject_o     (reject[c])
        );
    end

    cal_err_status #(.NUM_CH(NUM_CH)) u_status (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .reject_i (reject),
        .clear_i  (stat_clear),
        .err_o    (err)
    );

    always_comb begin
        bus_rdata_o = '0;
        unique case (sel)
            SEL_COEF: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (int'(bus_addr_i) == c) bus_rdata_o = coef_flat[c*COEF_W +: COEF_W];
                end
            end
            SEL_STAT: bus_rdata_o = {{PAD_W{1'b0}}, err};
            default:  bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/cal_coef_bank_chk.sv
module cal_coef_bank_chk #(
    parameter int NUM_CH = 3,
    parameter int COEF_W = 16,
    parameter int ADDR_W = 2
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic [NUM_CH-1:0]        ch_enable_i,
    input logic [NUM_CH-1:0]        ch_idle_i,
    input logic [NUM_CH-1:0]        cal_done_i,
    input logic [NUM_CH*COEF_W-1:0] cal_value_i,
    input logic                     bus_wr_i,
    input logic                     bus_rd_i,
    input logic [ADDR_W-1:0]        bus_addr_i,
    input logic [NUM_CH-1:0]        permit,
    input logic [NUM_CH-1:0]        reject,
    input logic [NUM_CH-1:0]        err,
    input logic [NUM_CH*COEF_W-1:0] coef_flat
);
    logic stat_rd;
    assign stat_rd = bus_rd_i && (int'(bus_addr_i) == NUM_CH);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        logic hit;
        assign hit = bus_wr_i && (int'(bus_addr_i) == c);

        p_cal_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cal_done_i[c] |=> coef_flat[c*COEF_W +: COEF_W] == $past(cal_value_i[c*COEF_W +: COEF_W]));

        p_permit_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            permit[c] |-> (ch_enable_i[c] && ch_idle_i[c]));

        p_refused_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hit && !permit[c] && !cal_done_i[c]) |=> $stable(coef_flat[c*COEF_W +: COEF_W]));

        p_refused_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hit && (!permit[c] || cal_done_i[c])) |=> err[c]);

        p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat_rd && !reject[c]) |=> !err[c]);

        p_collide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hit && cal_done_i[c]) |-> reject[c]);
    end
endmodule

bind cal_coef_bank cal_coef_bank_chk #(
    .NUM_CH (NUM_CH),
    .COEF_W (COEF_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ch_enable_i (ch_enable_i),
    .ch_idle_i   (ch_idle_i),
    .cal_done_i  (cal_done_i),
    .cal_value_i (cal_value_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .permit      (permit),
    .reject      (reject),
    .err         (err),
    .coef_flat   (coef_flat)
);

// File: tb/cal_coef_bank_tb.sv
module cal_coef_bank_tb;
    localparam int NCH  = 3;
    localparam int W    = 16;
    localparam int NIDL = 5;
    localparam int AW   = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH*W-1:0] defaults;
    logic [NCH-1:0] en = '0, idle = '0, cal = '0;
    logic [NCH*W-1:0] cal_val = '0;
    logic           wr = 1'b0, rd = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [W-1:0]   wdata = '0;
    logic [W-1:0]   rdata;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] m_coef [NCH];
    logic [NCH-1:0] m_err = '0;

    always #10 clk = ~clk;

    cal_coef_bank #(.NUM_CH(NCH), .COEF_W(W), .IDLE_CYCLES(NIDL), .ADDR_W(AW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .reset_coef_i(defaults),
        .ch_enable_i(en), .ch_idle_i(idle), .cal_done_i(cal), .cal_value_i(cal_val),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read all coefficients and the status (read clears status).
    task automatic verify(input string req);
        for (int c = 0; c < NCH; c++) begin
            addr = AW'(c); #1;
            chk(req, rdata, m_coef[c]);
        end
        addr = AW'(NCH); rd = 1'b1; #1;
        chk(req, rdata, {{(W-NCH){1'b0}}, m_err});
        @(negedge clk); rd = 1'b0; m_err = '0;
    endtask

    // Drop idle once, hold idle for k edges, then write (optionally with a cal strobe).
    task automatic window(input int ch, input int k, input logic [W-1:0] d,
                          input bit with_cal, input logic [W-1:0] cv);
        @(negedge clk); en[ch] = 1'b1; idle[ch] = 1'b0;
        @(negedge clk); idle[ch] = 1'b1;
        repeat (k) @(negedge clk);
        wr = 1'b1; addr = AW'(ch); wdata = d;
        if (with_cal) begin cal[ch] = 1'b1; cal_val[ch*W +: W] = cv; end
        @(negedge clk); wr = 1'b0; cal = '0;
        if (with_cal) begin m_coef[ch] = cv; m_err[ch] = 1'b1; end
        else if (k >= NIDL) m_coef[ch] = d;
        else m_err[ch] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            defaults[c*W +: W] = 16'hA000 + 16'(c) * 16'h0111;
            m_coef[c] = defaults[c*W +: W];
        end
        repeat (3) @(negedge clk);
        // R2: reset state (also exercises R1 and R7 read path)
        verify("R2 reset");
        rst_n = 1'b1;
        @(negedge clk);
        verify("R2 after release");

        // R4 and R6: sweep the idle window length on every channel
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k <= NIDL + 2; k++) begin
                window(c, k, 16'(16'h1000 * (c + 1) + k * 7), 1'b0, '0);
                verify($sformatf("R4/R6 ch%0d k%0d", c, k));
                idle[c] = 1'b0; en[c] = 1'b0;
            end
        end

        // R5: interruption by idle drop, then by disable
        for (int c = 0; c < NCH; c++) begin
            @(negedge clk); en[c] = 1'b1; idle[c] = 1'b1;
            repeat (NIDL - 1) @(negedge clk);
            idle[c] = 1'b0; @(negedge clk); idle[c] = 1'b1;
            repeat (NIDL - 1) @(negedge clk);
            wr = 1'b1; addr = AW'(c); wdata = 16'hDEAD; @(negedge clk); wr = 1'b0;
            m_err[c] = 1'b1;
            verify("R5 idle drop");
            repeat (NIDL) @(negedge clk);
            en[c] = 1'b0; @(negedge clk); en[c] = 1'b1;
            repeat (NIDL - 1) @(negedge clk);
            wr = 1'b1; addr = AW'(c); wdata = 16'hBEEF; @(negedge clk); wr = 1'b0;
            m_err[c] = 1'b1;
            verify("R5 disable");
            en[c] = 1'b0; idle[c] = 1'b0;
        end

        // R3: calibration strobe on disabled, busy channels; R1 read while not idle
        for (int c = 0; c < NCH; c++) begin
            @(negedge clk); cal[c] = 1'b1; cal_val[c*W +: W] = 16'h5A00 ^ 16'(c);
            @(negedge clk); cal = '0; m_coef[c] = 16'h5A00 ^ 16'(c);
            verify("R3 cal load / R1 read");
        end

        // R8: strobe and permitted write in the same cycle
        for (int c = 0; c < NCH; c++) begin
            window(c, NIDL, 16'h7777, 1'b1, 16'h3C30 + 16'(c));
            verify("R8 collision");
            idle[c] = 1'b0; en[c] = 1'b0;
        end

        // R9: write to the status address with every channel permitted
        en = '1; idle = '1;
        repeat (NIDL + 1) @(negedge clk);
        wr = 1'b1; addr = AW'(NCH); wdata = '1; @(negedge clk); wr = 1'b0;
        verify("R9 status write");

        // R7: second status read after a clear returns zero
        for (int c = 0; c < NCH; c++) begin
            en[c] = 1'b0;
            @(negedge clk); wr = 1'b1; addr = AW'(c); wdata = 16'h0F0F;
            @(negedge clk); wr = 1'b0; m_err[c] = 1'b1;
        end
        verify("R7 read returns bits");
        verify("R7 cleared");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule